// File: doc/BRIEF.md
# Synchronous FIFO with Reset-Loaded Almost-Flag Thresholds

This block is a single-clock first-in first-out buffer for 9-bit words. It reports empty and full status. It also reports almost-empty and almost-full status, and the thresholds for these come from a configuration word. The word is loaded through the ordinary write port while the active-low master reset is held. A write made during reset goes to the configuration register and never to the buffer. A read made during reset shows the register's contents on the read-data output, so the loaded value can be checked. If a reset period passes with no write, the register takes a default value.

The low six bits of the configuration word form a step count P, and each almost flag is active within 16·P words of its boundary. The upper three bits are not used here. They are passed out unchanged for a separate parity unit. One active-low output shows that an almost condition holds, and a companion output tells which of the two it is.

Top module: `progflag_fifo`

## Requirements
- R1: A write while `mrstN` is low stores `wrData` into the configuration register and puts nothing in the buffer. After release the FIFO is empty.
- R2: A read while `mrstN` is low loads `rdData`, at that clock edge, with the configuration word held just before the edge.
- R3: Each clock edge inside a reset period with no write so far loads the default word 9'h001 (P = 1, upper bits zero). A reset period with no write therefore leaves that value in the register.
- R4: `almostEmpty` is high exactly when the occupancy is at most 16·P, where P is bits 5:0 of the configuration word.
- R5: `almostFull` is high exactly when the occupancy is at least DEPTH − 16·P.
- R6: `progFlagN` is low exactly when `almostEmpty` or `almostFull` is high. `progFlagSel` is high exactly when `almostFull` is high.
- R7: `parityCfg` always equals bits 8:6 of the configuration word.
- R8: Outside reset, the buffer returns words in write order. A read accepted at an edge presents the oldest word on `rdData` after that edge. A simultaneous read and write is allowed.
- R9: A write while full is ignored, and so is a read while empty. `rdData` and the occupancy are left unchanged.
- R10: `empty` is high when the occupancy is 0, and `full` is high when it equals DEPTH. At the end of every reset period the occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrstN | input | 1 | Active-low master reset and configuration window |
| wrEn | input | 1 | Write request |
| wrData | input | 9 | Write data or configuration word |
| rdEn | input | 1 | Read request |
| rdData | output | 9 | Registered read data or configuration readback |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| almostEmpty | output | 1 | Occupancy at most 16·P |
| almostFull | output | 1 | Occupancy at least DEPTH − 16·P |
| progFlagN | output | 1 | Low when either almost flag is active |
| progFlagSel | output | 1 | High when the active almost state is almost-full |
| parityCfg | output | 3 | Bits 8:6 of the configuration word |

## Verification
All status outputs are decoded from registered occupancy and configuration, so they reflect a request one clock edge after it is sampled. `rdData` is also registered, and it shows the popped word or the configuration readback right after the edge that accepted the read. The bench drives each request just after a falling edge and updates its queue-based model at the rising edge. It then compares every output at the next falling edge, which is exactly one edge after the stimulus. The model rests only on the stated rules: occupancy bounds, thresholds of 16·P, and the reset-window load and default.

// File: rtl/progflag_fifo_pkg.sv
package progflag_fifo_pkg;

  typedef struct packed {
    logic wrPush;
    logic rdPop;
    logic cfgLoad;
    logic cfgDefault;
    logic cfgShow;
    logic ptrClear;
  } fifoStrobes_t;

  localparam int CFG_W = 9;
  localparam int STEP_W = 6;
  localparam int STEP_SHIFT = 4;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 9'h001;

endpackage

// File: rtl/progflag_fifo_ctrl.sv
module progflag_fifo_ctrl
  import progflag_fifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic              mrstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [STEP_W-1:0] stepCount,
  output fifoStrobes_t      strobes,
  output logic              empty,
  output logic              full,
  output logic              almostEmpty,
  output logic              almostFull
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = ((CW > STEP_W + STEP_SHIFT) ? CW : STEP_W + STEP_SHIFT) + 1;

  logic [CW-1:0] count;
  logic          wroteInReset;
  logic [TW-1:0] thr;
  logic [TW-1:0] countWide;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_comb begin
    strobes            = '0;
    strobes.ptrClear   = !mrstN;
    strobes.cfgLoad    = !mrstN && wrEn;
    strobes.cfgDefault = !mrstN && !wrEn && !wroteInReset;
    strobes.cfgShow    = !mrstN && rdEn;
    strobes.wrPush     = mrstN && wrEn && !full;
    strobes.rdPop      = mrstN && rdEn && !empty;
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      count        <= '0;
      wroteInReset <= wroteInReset | wrEn;
    end else begin
      wroteInReset <= 1'b0;
      case ({strobes.wrPush, strobes.rdPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign thr       = TW'(stepCount) << STEP_SHIFT;
  assign countWide = TW'(count);

  assign almostEmpty = (countWide <= thr);
  assign almostFull  = ((countWide + thr) >= TW'(DEPTH));

  // R9: a rejected write on a full buffer keeps it full
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!mrstN)
    (full && wrEn && !rdEn) |=> full);

  // R9: a rejected read on an empty buffer keeps it empty
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!mrstN)
    (empty && rdEn && !wrEn) |=> empty);

  // R10: the reset period always ends with an empty buffer
  a_r10_empty_after_reset: assert property (@(posedge clk) disable iff (!mrstN)
    $rose(mrstN) |-> empty);

  // R10: occupancy stays within the buffer bounds
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!mrstN)
    count <= CW'(DEPTH));

  // R8: occupancy moves by at most one word per edge
  a_r8_single_step: assert property (@(posedge clk) disable iff (!mrstN)
    !$stable(count) |-> ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

endmodule

// File: rtl/progflag_fifo_dp.sv
module progflag_fifo_dp
  import progflag_fifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  fifoStrobes_t     strobes,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] rdData,
  output logic [CFG_W-1:0] cfgWord
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2 = ((1 << AW) == DEPTH);

  logic [CFG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW-1:0]    wrPtrNext;
  logic [AW-1:0]    rdPtrNext;

  generate
    if (POW2) begin : g_wrapFree
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrPtrNext = (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.ptrClear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrPush) wrPtr <= wrPtrNext;
      if (strobes.rdPop)  rdPtr <= rdPtrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobes.cfgLoad)         cfgWord <= wrData;
    else if (strobes.cfgDefault) cfgWord <= CFG_DEFAULT;
  end

  always_ff @(posedge clk) begin
    if (strobes.cfgShow)    rdData <= cfgWord;
    else if (strobes.rdPop) rdData <= mem[rdPtr];
  end

  // R1: the configuration register takes the word written in reset
  a_r1_cfg_capture: assert property (@(posedge clk)
    strobes.cfgLoad |=> (cfgWord == $past(wrData)));

  // R1: reset-time traffic never touches the buffer
  a_r1_no_push_in_reset: assert property (@(posedge clk)
    strobes.ptrClear |-> !strobes.wrPush && !strobes.rdPop);

endmodule

// File: rtl/progflag_fifo.sv
module progflag_fifo
  import progflag_fifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       mrstN,
  input  logic       wrEn,
  input  logic [8:0] wrData,
  input  logic       rdEn,
  output logic [8:0] rdData,
  output logic       empty,
  output logic       full,
  output logic       almostEmpty,
  output logic       almostFull,
  output logic       progFlagN,
  output logic       progFlagSel,
  output logic [2:0] parityCfg
);

  fifoStrobes_t     strobes;
  logic [CFG_W-1:0] cfgWord;

  progflag_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .mrstN      (mrstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .stepCount  (cfgWord[STEP_W-1:0]),
    .strobes    (strobes),
    .empty      (empty),
    .full       (full),
    .almostEmpty(almostEmpty),
    .almostFull (almostFull)
  );

  progflag_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData),
    .cfgWord(cfgWord)
  );

  assign progFlagN   = !(almostEmpty || almostFull);
  assign progFlagSel = almostFull;
  assign parityCfg   = cfgWord[CFG_W-1:STEP_W];

endmodule

// File: tb/progflag_fifo_tb.sv
module progflag_fifo_tb;

  localparam int DEPTH = 1024;

  logic       clk = 1'b0;
  logic       mrstN = 1'b1;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [8:0] rdData;
  logic       empty, full, almostEmpty, almostFull, progFlagN, progFlagSel;
  logic [2:0] parityCfg;

  always #4 clk = ~clk;

  progflag_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .mrstN(mrstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .empty(empty), .full(full), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .progFlagN(progFlagN), .progFlagSel(progFlagSel),
    .parityCfg(parityCfg)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit modelOn = 0;

  logic [8:0] q[$];
  logic [8:0] mCfg = 9'h001;
  logic [8:0] mRd = '0;
  bit         mRdKnown = 0;
  bit         mWrote = 0;
  string      rdTag = "R8";

  task automatic check(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, actual, expected, $time);
    end
  endtask

  always @(posedge clk) begin
    if (modelOn) begin
      if (!mrstN) begin
        if (rdEn) begin mRd = mCfg; mRdKnown = 1; rdTag = "R2"; end
        if (wrEn) begin mCfg = wrData; mWrote = 1; end
        else if (!mWrote) mCfg = 9'h001;
        q.delete();
      end else begin
        bit wasEmpty, wasFull;
        mWrote = 0;
        wasEmpty = (q.size() == 0);
        wasFull  = (q.size() == DEPTH);
        if (rdEn && !wasEmpty) begin mRd = q[0]; mRdKnown = 1; rdTag = "R8"; end
        if (wrEn && !wasFull) q.push_back(wrData);
        if (rdEn && !wasEmpty) void'(q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      int n, thr;
      bit eAe, eAf;
      n = q.size();
      thr = 16 * int'(mCfg[5:0]);
      eAe = (n <= thr);
      eAf = (n >= DEPTH - thr);
      check("R10", "empty", int'(empty), int'(n == 0));
      check("R10", "full", int'(full), int'(n == DEPTH));
      check("R4", "almostEmpty", int'(almostEmpty), int'(eAe));
      check("R5", "almostFull", int'(almostFull), int'(eAf));
      check("R6", "progFlagN", int'(progFlagN), int'(!(eAe || eAf)));
      check("R6", "progFlagSel", int'(progFlagSel), int'(eAf));
      check("R7", "parityCfg", int'(parityCfg), int'(mCfg[8:6]));
      if (mRdKnown) check(rdTag, "rdData", int'(rdData), int'(mRd));
    end
  end

  task automatic step(bit mr, bit we, logic [8:0] wd, bit re);
    mrstN = mr; wrEn = we; wrData = wd; rdEn = re;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic resetWith(bit doWrite, logic [8:0] word);
    step(0, 0, '0, 0);
    if (doWrite) step(0, 1, word, 0);
    step(0, 0, '0, 1);
    step(0, 0, '0, 0);
    step(1, 0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, '0, 0);
    step(1, 0, '0, 0);
    modelOn = 1;

    // R3: reset with no write loads the default word, read back in reset (R2)
    resetWith(0, '0);
    check("R3", "default readback", int'(rdData), 'h001);
    check("R10", "empty after reset", int'(empty), 1);

    // R1: write P=2, parity bits 111 during reset, then read it back
    resetWith(1, 9'h1C2);
    check("R1", "written word readback", int'(rdData), 'h1C2);
    check("R1", "buffer empty after config write", int'(empty), 1);
    check("R7", "parity bits", int'(parityCfg), 3'b111);

    // R8, R4, R5: fill the whole buffer
    for (int i = 0; i < DEPTH; i++) step(1, 1, 9'(i * 7 + 3), 0);
    check("R10", "full after fill", int'(full), 1);
    // R9: write while full is ignored
    step(1, 1, 9'h155, 0);
    step(1, 1, 9'h0AA, 0);
    check("R9", "still full", int'(full), 1);
    // simultaneous read and write while full: read taken, write rejected
    step(1, 1, 9'h1FF, 1);
    check("R9", "full rejects write on pop", int'(full), 0);
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0, 1);
    check("R10", "empty after drain", int'(empty), 1);
    // R9: read while empty leaves rdData held
    begin
      logic [8:0] held;
      held = rdData;
      step(1, 0, '0, 1);
      step(1, 0, '0, 1);
      check("R9", "rdData held on empty read", int'(rdData), int'(held));
    end

    // R4/R5 with P=0: flags only at the boundaries
    resetWith(1, 9'h040);
    for (int i = 0; i < 40; i++) step(1, 1, 9'(i + 100), (i % 3) == 2);
    for (int i = 0; i < 30; i++) step(1, (i % 2) == 0, 9'(i), 1);

    // P=63: overlapping almost windows
    resetWith(1, 9'h03F);
    for (int i = 0; i < 60; i++) step(1, 1, 9'(i * 5), 0);
    for (int i = 0; i < 60; i++) step(1, 1, 9'(i + 9), 1);
    for (int i = 0; i < 70; i++) step(1, 0, '0, 1);

    // R1: reset in mid-stream discards contents, two writes: last wins
    for (int i = 0; i < 10; i++) step(1, 1, 9'(i), 0);
    step(0, 1, 9'h0C5, 0);
    step(0, 1, 9'h183, 1);
    step(0, 0, '0, 1);
    check("R1", "last reset write kept", int'(rdData), 'h183);
    step(1, 0, '0, 0);
    check("R10", "empty after mid reset", int'(empty), 1);
    for (int i = 0; i < 60; i++) step(1, 1, 9'(i ^ 9'h0F0), i > 20);
    for (int i = 0; i < 45; i++) step(1, 0, '0, 1);

    modelOn = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule